// File: doc/BRIEF.md
# Programmable Channel Crossbar Receive Port

This block is the receiving end of a parallel bit-stream port with sixteen one-bit data channels, a once-per-second marker channel and a clock-enable qualifier. The bit-stream rate may equal the channel clock or be any binary fraction of it. The enable marks the channel-clock cycles that carry new bits, and only those cycles produce output samples.

Every internal channel position takes its bit from any external channel through a programmable crossbar. Only the lowest N internal positions are forwarded, where N is the active-channel count (1, 2, 4, 8 or 16). Positions at or above N are driven to zero. An optional validity port passes through a second crossbar with the same settings.

Configuration is written through a small register port into shadow registers. The shadow values become live only on a sample that carries the second marker, so one second never mixes two mappings. Each output sample leaves with a valid strobe and a start-of-second flag.

Top module: `xbar_rx_port`

## Requirements
- R1: After reset, fwd_valid, fwd_sos, fwd_bits and fwd_vbits are 0. The live mapping is identity (internal channel i takes external channel i) and the live active count is 16.
- R2: A write to address a (0..15) sets the shadow source of internal channel a to cfg_wr_data[3:0]. Once live, fwd_bits[a] equals rx_bits[source] of the corresponding sample.
- R3: A write to address 16 sets the shadow active count. When that count N is live, fwd_bits[i] and fwd_vbits[i] are 0 for every i >= N, whatever the inputs.
- R4: A count write whose value is not 1, 2, 4, 8 or 16 is dropped, and the earlier shadow count stays.
- R5: Shadow settings become live on a sample where rx_ce and rx_sec_mark are both high, and that sample is already routed with the new settings. A marker with rx_ce low commits nothing.
- R6: A sample presented with rx_ce high appears on the outputs two clock edges later, with fwd_valid high for exactly one cycle. A cycle with rx_ce low gives fwd_valid low and leaves fwd_bits and fwd_vbits unchanged.
- R7: fwd_sos is high with the output sample that was taken while rx_sec_mark was high, and at no other time.
- R8: fwd_vbits is routed and masked from rx_vbits using the same live mapping and count as fwd_bits.
- R9: A shadow write with no later marker sample leaves the routing of the following samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bits | input | 16 | External data channels |
| rx_vbits | input | 16 | External validity channels |
| rx_sec_mark | input | 1 | Once-per-second marker |
| rx_ce | input | 1 | Bit-stream clock enable |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 5 | 0..15 crossbar entry, 16 active count |
| cfg_wr_data | input | 5 | Write value |
| fwd_bits | output | 16 | Routed, masked data sample |
| fwd_vbits | output | 16 | Routed, masked validity sample |
| fwd_valid | output | 1 | Sample strobe |
| fwd_sos | output | 1 | Start-of-second flag |

## Verification
A wrong crossbar entry shows as one swapped or stuck output bit on the first valid sample after the marker that commits it. A wrong live count shows as unmasked or wrongly zeroed upper positions on that same sample. A commit at the wrong time shows on the sample just before the marker: that sample is routed with settings that should not be live yet. The sweep crosses several permutations with every legal count and checks each sample two edges after it is presented, so each fault shows within one sample period.

// File: rtl/xbar_rx_pkg.sv
package xbar_rx_pkg;

   // Kind of configuration access decoded from the write address
   typedef enum logic [1:0] {
      CFG_NONE  = 2'd0,
      CFG_MAP   = 2'd1,
      CFG_COUNT = 2'd2
   } cfg_kind_e;

   // Active count must be a nonzero power of two no larger than the channel count
   function automatic bit count_is_legal(input int unsigned v, input int unsigned lim);
      return (v != 0) && ((v & (v - 1)) == 0) && (v <= lim);
   endfunction

endpackage

// File: rtl/xbar_rx_capture.sv
module xbar_rx_capture #(
   parameter int NUM_CH  = 16,
   parameter bit HAS_VLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] data_i,
   input  logic [NUM_CH-1:0] vld_i,
   input  logic              mark_i,
   input  logic              ce_i,
   output logic [NUM_CH-1:0] data_q,
   output logic [NUM_CH-1:0] vld_q,
   output logic              mark_q,
   output logic              ce_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         mark_q <= 1'b0;
         ce_q   <= 1'b0;
      end else begin
         data_q <= data_i;
         mark_q <= mark_i;
         ce_q   <= ce_i;
      end
   end

   generate
      if (HAS_VLD) begin : g_vld
         always_ff @(posedge clk) begin
            if (!rst_n) vld_q <= '0;
            else        vld_q <= vld_i;
         end
      end else begin : g_no_vld
         assign vld_q = '0;
      end
   endgenerate

endmodule

// File: rtl/xbar_rx_cfg.sv
module xbar_rx_cfg
   import xbar_rx_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int SEL_W  = $clog2(NUM_CH),
   parameter int CNT_W  = SEL_W + 1,
   parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [CNT_W-1:0]        wdata_i,
   input  logic                    commit_i,
   output logic [NUM_CH*SEL_W-1:0] live_map_o,
   output logic [CNT_W-1:0]        live_cnt_o,
   output logic [NUM_CH*SEL_W-1:0] shd_map_o,
   output logic [CNT_W-1:0]        shd_cnt_o
);

   localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(NUM_CH);
   localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(NUM_CH);

   cfg_kind_e kind;
   logic      cnt_ok;

   always_comb begin
      kind = CFG_NONE;
      if (we_i) begin
         if (addr_i < CNT_ADDR)       kind = CFG_MAP;
         else if (addr_i == CNT_ADDR) kind = CFG_COUNT;
      end
   end

   assign cnt_ok = count_is_legal(int'(wdata_i), NUM_CH);

   // Count registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_cnt_o  <= CNT_MAX;
         live_cnt_o <= CNT_MAX;
      end else begin
         if (kind == CFG_COUNT && cnt_ok) shd_cnt_o <= wdata_i;
         if (commit_i)                    live_cnt_o <= shd_cnt_o;
      end
   end

   // One shadow/live pair per internal channel, identity after reset
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shd_map_o[i*SEL_W +: SEL_W]  <= SEL_W'(i);
               live_map_o[i*SEL_W +: SEL_W] <= SEL_W'(i);
            end else begin
               if (kind == CFG_MAP && addr_i == ADDR_W'(i))
                  shd_map_o[i*SEL_W +: SEL_W] <= wdata_i[SEL_W-1:0];
               if (commit_i)
                  live_map_o[i*SEL_W +: SEL_W] <= shd_map_o[i*SEL_W +: SEL_W];
            end
         end
      end
   endgenerate

   // R5: live settings move only on a commit
   p_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> ($stable(live_cnt_o) && $stable(live_map_o)));

   // R4: an illegal count write leaves the shadow count alone
   p_reject_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == CNT_ADDR && !cnt_ok) |=> $stable(shd_cnt_o));

   // R3: the live count is always a legal power of two
   p_live_count_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(live_cnt_o) == 1) && (live_cnt_o <= CNT_MAX));

endmodule

// File: rtl/xbar_rx_xbar.sv
module xbar_rx_xbar #(
   parameter int NUM_CH = 16,
   parameter int SEL_W  = $clog2(NUM_CH),
   parameter int CNT_W  = SEL_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic [NUM_CH-1:0]       bits_i,
   input  logic [NUM_CH*SEL_W-1:0] map_i,
   input  logic [CNT_W-1:0]        cnt_i,
   output logic [NUM_CH-1:0]       bits_o
);

   logic [NUM_CH-1:0] routed;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_out
         logic [SEL_W-1:0] src;
         assign src       = map_i[i*SEL_W +: SEL_W];
         assign routed[i] = (CNT_W'(i) < cnt_i) ? bits_i[src] : 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    bits_o <= '0;
      else if (en_i) bits_o <= routed;
   end

   // R6: output bits hold when no sample is taken
   p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(bits_o));

endmodule

// File: rtl/xbar_rx_port.sv
module xbar_rx_port
   import xbar_rx_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter bit HAS_VLD = 1'b1,
   parameter int SEL_W   = $clog2(NUM_CH),
   parameter int CNT_W   = SEL_W + 1,
   parameter int ADDR_W  = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] rx_bits,
   input  logic [NUM_CH-1:0] rx_vbits,
   input  logic              rx_sec_mark,
   input  logic              rx_ce,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_wr_addr,
   input  logic [CNT_W-1:0]  cfg_wr_data,
   output logic [NUM_CH-1:0] fwd_bits,
   output logic [NUM_CH-1:0] fwd_vbits,
   output logic              fwd_valid,
   output logic              fwd_sos
);

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("xbar_rx_port: NUM_CH must be a power of two, at least 2");
      end
      if (SEL_W != $clog2(NUM_CH) || CNT_W != SEL_W + 1) begin : g_bad_w
         $error("xbar_rx_port: derived widths must not be overridden");
      end
   endgenerate

   logic [NUM_CH-1:0]       data_q, vld_q;
   logic                    mark_q, ce_q, commit;
   logic [NUM_CH*SEL_W-1:0] live_map, shd_map, eff_map;
   logic [CNT_W-1:0]        live_cnt, shd_cnt, eff_cnt;

   xbar_rx_capture #(.NUM_CH(NUM_CH), .HAS_VLD(HAS_VLD)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .data_i(rx_bits), .vld_i(rx_vbits), .mark_i(rx_sec_mark), .ce_i(rx_ce),
      .data_q(data_q), .vld_q(vld_q), .mark_q(mark_q), .ce_q(ce_q)
   );

   assign commit = ce_q & mark_q;

   xbar_rx_cfg #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .we_i(cfg_wr_en), .addr_i(cfg_wr_addr), .wdata_i(cfg_wr_data),
      .commit_i(commit),
      .live_map_o(live_map), .live_cnt_o(live_cnt),
      .shd_map_o(shd_map), .shd_cnt_o(shd_cnt)
   );

   // The marker sample already uses the settings it commits
   assign eff_map = commit ? shd_map : live_map;
   assign eff_cnt = commit ? shd_cnt : live_cnt;

   xbar_rx_xbar #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_dxb (
      .clk(clk), .rst_n(rst_n), .en_i(ce_q),
      .bits_i(data_q), .map_i(eff_map), .cnt_i(eff_cnt), .bits_o(fwd_bits)
   );

   generate
      if (HAS_VLD) begin : g_vxb
         xbar_rx_xbar #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_vxb (
            .clk(clk), .rst_n(rst_n), .en_i(ce_q),
            .bits_i(vld_q), .map_i(eff_map), .cnt_i(eff_cnt), .bits_o(fwd_vbits)
         );
      end else begin : g_no_vxb
         assign fwd_vbits = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid <= 1'b0;
         fwd_sos   <= 1'b0;
      end else begin
         fwd_valid <= ce_q;
         fwd_sos   <= commit;
      end
   end

   // R7: the start-of-second flag only rides on a valid sample
   p_sos_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sos |-> fwd_valid);

   // R6: the strobe follows the captured enable by one edge
   p_valid_tracks_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid == $past(ce_q));

endmodule

// File: tb/xbar_rx_port_tb_top.sv
module xbar_rx_port_tb_top;

   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  rx_bits = '0, rx_vbits = '0;
   logic          rx_sec_mark = 1'b0, rx_ce = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [4:0]    cfg_wr_addr = '0;
   logic [4:0]    cfg_wr_data = '0;
   logic [N-1:0]  fwd_bits, fwd_vbits;
   logic          fwd_valid, fwd_sos;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // Bench model: shadow and live settings
   int bmap[N], smap[N];
   int bcnt, scnt;
   logic [N-1:0] exp_bits, exp_vbits;

   always #4 clk = ~clk;  // 125 MHz

   xbar_rx_port dut_i (
      .clk(clk), .rst_n(rst_n),
      .rx_bits(rx_bits), .rx_vbits(rx_vbits),
      .rx_sec_mark(rx_sec_mark), .rx_ce(rx_ce),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .fwd_bits(fwd_bits), .fwd_vbits(fwd_vbits),
      .fwd_valid(fwd_valid), .fwd_sos(fwd_sos)
   );

   function automatic logic [N-1:0] route(input logic [N-1:0] d);
      logic [N-1:0] r = '0;
      for (int i = 0; i < N; i++) r[i] = (i < bcnt) ? d[bmap[i]] : 1'b0;
      return r;
   endfunction

   function automatic bit legal(input int v);
      return (v == 1) || (v == 2) || (v == 4) || (v == 8) || (v == 16);
   endfunction

   task automatic chk(input string req, input string what, input logic [N-1:0] act,
                      input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int addr, input int val);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = 5'(addr); cfg_wr_data = 5'(val);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (addr < N) smap[addr] = val % N;
      else if (addr == N && legal(val)) scnt = val;
   endtask

   // Presents one cycle of input, then checks the outputs two edges later
   task automatic apply(input logic [N-1:0] d, input logic [N-1:0] v,
                        input logic mk, input logic ce, input string req);
      @(negedge clk);
      rx_bits = d; rx_vbits = v; rx_sec_mark = mk; rx_ce = ce;
      @(negedge clk);
      rx_ce = 1'b0; rx_sec_mark = 1'b0;
      if (ce) begin
         if (mk) begin
            bmap = smap; bcnt = scnt;
         end
         exp_bits = route(d); exp_vbits = route(v);
      end
      @(negedge clk);
      chk(req, "bits",  fwd_bits,  exp_bits);
      chk(req, "vbits", fwd_vbits, exp_vbits);
      chk(req, "valid", N'(fwd_valid), N'(ce));
      chk("R7", "sos",  N'(fwd_sos),  N'(ce & mk));
   endtask

   function automatic int scheme(input int s, input int i);
      case (s)
         0: return i;
         1: return N - 1 - i;
         2: return (i + 5) % N;
         3: return (i * 3) % N;
         default: return 7;
      endcase
   endfunction

   initial begin
      for (int i = 0; i < N; i++) begin bmap[i] = i; smap[i] = i; end
      bcnt = N; scnt = N; exp_bits = '0; exp_vbits = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "bits",  fwd_bits,  '0);
      chk("R1", "vbits", fwd_vbits, '0);
      chk("R1", "valid", N'(fwd_valid), '0);
      chk("R1", "sos",   N'(fwd_sos),   '0);
      apply(16'hA5C3, 16'h0F0F, 1'b0, 1'b1, "R1");

      // R6: idle cycle holds data, no strobe
      apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R6");
      apply(16'h1234, 16'h8001, 1'b0, 1'b1, "R6");
      // R5: marker with enable low commits nothing
      cfg_write(N, 1);
      apply(16'h0000, 16'h0000, 1'b1, 1'b0, "R5");
      apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R5");

      // Sweep mappings against every legal count
      for (int s = 0; s < 5; s++) begin
         for (int c = 1; c <= N; c = c * 2) begin
            for (int i = 0; i < N; i++) cfg_write(i, scheme(s, i));
            cfg_write(N, c);
            // R9: not live before a marker sample
            apply(16'h6D2B ^ 16'(s * 977), 16'hB4E1, 1'b0, 1'b1, "R9");
            // R5: the marker sample uses the new settings
            apply(16'hC35A ^ 16'(c * 131), 16'h5AC3, 1'b1, 1'b1, "R5");
            for (int p = 0; p < N; p++) begin
               logic [N-1:0] onehot = N'(1) << p;
               apply(onehot, ~onehot, 1'b0, 1'b1, (p % 2) ? "R2" : "R8");
            end
            apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R3");
         end
      end

      // R4: illegal counts leave count 4 in place
      cfg_write(N, 4);
      apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R4");
      foreach (legal_bad_vals[k]) begin
         cfg_write(N, legal_bad_vals[k]);
         apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R4");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   int legal_bad_vals[6] = '{0, 3, 5, 12, 17, 31};

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule